// File: doc/BRIEF.md
# Secure-Filtering AXI4-Lite to APB Bridge

This bridge sits between an AXI4-Lite request port and a shared APB bus that serves a fixed group of peripherals. Each incoming single-beat read or write carries the non-secure bit of the AXI protection field. An address decoder maps the request onto one of the peripheral select lines. APB has no way to tell a peripheral whether a request is secure, so the bridge itself decides whether the request may go out.

A static vector holds one bit per peripheral. A set bit marks that peripheral as secure. A non-secure request that decodes to a secure peripheral is refused inside the bridge and gets an error response, and no APB cycle starts. A secure request may reach any peripheral. A request that falls outside every window gets a decode error. A permitted request runs a normal APB setup phase and then an access phase. The peripheral's error flag is passed back as a slave error.

The bridge handles one request at a time. If a complete write (address and data) and a read arrive in the same cycle, the write is taken first.

Top module: `secure_apb_bridge`

## Requirements
- R1: After reset no peripheral select is high, the enable strobe is low, and neither the write response valid nor the read response valid is high.
- R2: Peripheral k (k = 0..NUM_PERIPH-1) owns the 4 KB window starting at BASE_ADDR + k*4096. A permitted request to that window drives select bit k alone high, and puts the full request address on paddr (and, for a write, the write data on pwdata).
- R3: A permitted request first spends exactly one cycle with the select high and the enable low. The enable then rises, and the access phase lasts until the first cycle in which pready is high, so there are (wait cycles + 1) access cycles.
- R4: A request whose non-secure bit is 0 reaches a peripheral whether its configuration bit is 0 or 1.
- R5: A request whose non-secure bit is 1 reaches a peripheral whose configuration bit is 0 and completes with OKAY (2'b00).
- R6: A request whose non-secure bit is 1 and that decodes to a peripheral whose configuration bit is 1 raises no select line. It completes with SLVERR (2'b10), and a refused read returns data 0.
- R7: An address outside every peripheral window raises no select line and completes with DECERR (2'b11). A read of such an address returns data 0.
- R8: A permitted read returns prdata as sampled in the access cycle where pready is high. pslverr high in that cycle gives SLVERR (2'b10); pslverr low gives OKAY (2'b00).
- R9: From the cycle a request is accepted until its response handshake completes, awready, wready and arready stay low.
- R10: When awvalid, wvalid and arvalid are all high in an idle cycle, the write is accepted and arready stays low. The read is served after the write response completes.
- R11: A response stays valid with a stable code until the master accepts it with bready or rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_secure | input | NUM_PERIPH | Bit k set marks peripheral k as secure |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write address |
| awprot_ns | input | 1 | Non-secure bit of the write protection field |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read address |
| arprot_ns | input | 1 | Non-secure bit of the read protection field |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| psel | output | NUM_PERIPH | One select line per peripheral |
| penable | output | 1 | APB enable strobe |
| pwrite | output | 1 | APB direction, 1 for write |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB write strobes, zero on reads |
| prdata | input | DATA_W | Read data from the selected peripheral |
| pready | input | 1 | Access-phase completion from the peripheral |
| pslverr | input | 1 | Error flag from the peripheral |

## Verification
The bench aims at the security gate from both sides. It sends non-secure reads and writes to secure peripherals, where a filter that leaks would show a select pulse or return OKAY. It also sends secure requests to secure peripherals, where a filter that is too strict would return a false SLVERR. Unmapped addresses check that a miss gives DECERR and not SLVERR, and that it starts no APB cycle. Wait states and pslverr check that the access phase neither ends early nor hides a peripheral error. A simultaneous write and read, and a response held against a low ready, catch a bridge that takes the read first, accepts a second request while busy, or drops its response before the master takes it.

// File: rtl/secbr_pkg.sv
package secbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_RESP
    } br_state_e;

    typedef enum logic [1:0] {
        DEC_PASS,
        DEC_BLOCK,
        DEC_MISS
    } dec_res_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    function automatic logic [1:0] apb_to_resp(input logic err);
        return err ? RESP_SLVERR : RESP_OKAY;
    endfunction

endpackage

// File: rtl/secbr_decode.sv
module secbr_decode
    import secbr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          NUM_PERIPH = 8,
    parameter int          WIN_W      = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
    localparam int         IDX_W      = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
    localparam int         SPAN_W     = WIN_W + IDX_W
) (
    input  logic [ADDR_W-1:WIN_W]  addr_hi,
    input  logic                   nonsec,
    input  logic [NUM_PERIPH-1:0]  cfg_secure,
    output logic [IDX_W-1:0]       idx,
    output dec_res_e               result
);

    logic region_hit;
    logic idx_valid;

    assign idx        = addr_hi[SPAN_W-1:WIN_W];
    assign region_hit = (addr_hi[ADDR_W-1:SPAN_W] == BASE_ADDR[ADDR_W-1:SPAN_W]);
    assign idx_valid  = (int'(idx) < NUM_PERIPH);

    always_comb begin
        if (!region_hit || !idx_valid) begin
            result = DEC_MISS;
        end else if (nonsec && cfg_secure[idx]) begin
            result = DEC_BLOCK;
        end else begin
            result = DEC_PASS;
        end
    end

endmodule

// File: rtl/secbr_apb_seq.sv
module secbr_apb_seq
    import secbr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_PERIPH = 8,
    localparam int IDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
    localparam int STRB_W    = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_wr,
    input  logic                  start_rd,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [STRB_W-1:0]     req_strb,
    input  dec_res_e              dec_res,
    input  logic [IDX_W-1:0]      dec_idx,
    output logic                  idle,
    output logic                  bvalid,
    input  logic                  bready,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [1:0]            resp,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_PERIPH-1:0] psel,
    output logic                  penable,
    output logic                  pwrite,
    output logic [ADDR_W-1:0]     paddr,
    output logic [DATA_W-1:0]     pwdata,
    output logic [STRB_W-1:0]     pstrb,
    input  logic [DATA_W-1:0]     prdata,
    input  logic                  pready,
    input  logic                  pslverr
);

    br_state_e         state_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [STRB_W-1:0] strb_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        resp_q;
    logic [DATA_W-1:0] rdata_q;
    logic              start;
    logic              apb_active;

    assign start = start_wr || start_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            strb_q  <= '0;
            idx_q   <= '0;
            resp_q  <= RESP_OKAY;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        wr_q    <= start_wr;
                        addr_q  <= req_addr;
                        wdata_q <= start_wr ? req_wdata : '0;
                        strb_q  <= start_wr ? req_strb : '0;
                        idx_q   <= dec_idx;
                        rdata_q <= '0;
                        case (dec_res)
                            DEC_PASS: begin
                                resp_q  <= RESP_OKAY;
                                state_q <= ST_SETUP;
                            end
                            DEC_BLOCK: begin
                                resp_q  <= RESP_SLVERR;
                                state_q <= ST_RESP;
                            end
                            default: begin
                                resp_q  <= RESP_DECERR;
                                state_q <= ST_RESP;
                            end
                        endcase
                    end
                end
                ST_SETUP: state_q <= ST_ACCESS;
                ST_ACCESS: begin
                    if (pready) begin
                        resp_q  <= apb_to_resp(pslverr);
                        rdata_q <= wr_q ? '0 : prdata;
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (wr_q ? bready : rready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle       = (state_q == ST_IDLE);
    assign apb_active = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
    assign penable    = (state_q == ST_ACCESS);
    assign pwrite     = wr_q;
    assign paddr      = addr_q;
    assign pwdata     = wdata_q;
    assign pstrb      = strb_q;
    assign bvalid     = (state_q == ST_RESP) && wr_q;
    assign rvalid     = (state_q == ST_RESP) && !wr_q;
    assign resp       = resp_q;
    assign rdata      = rdata_q;

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_sel
        assign psel[g] = apb_active && (int'(idx_q) == g);
    end

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(psel));

    a_r3_setup_then_access: assert property (@(posedge clk) disable iff (rst)
        ((|psel) && !penable) |=> ((|psel) && penable));

    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (penable && !pready) |=> (penable && $stable(psel) && $stable(paddr) && $stable(pwdata)));

    a_r6_block_no_apb: assert property (@(posedge clk) disable iff (rst)
        (idle && start && dec_res == DEC_BLOCK) |=> (psel == '0 && (bvalid || rvalid) && resp == RESP_SLVERR));

    a_r7_miss_decerr: assert property (@(posedge clk) disable iff (rst)
        (idle && start && dec_res == DEC_MISS) |=> (psel == '0 && (bvalid || rvalid) && resp == RESP_DECERR));

    a_r11_bresp_held: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> (bvalid && $stable(resp)));

    a_r11_rresp_held: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(resp) && $stable(rdata)));

endmodule

// File: rtl/secure_apb_bridge.sv
module secure_apb_bridge
    import secbr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          NUM_PERIPH = 8,
    parameter int          WIN_W      = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000,
    localparam int         IDX_W      = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
    localparam int         STRB_W     = DATA_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PERIPH-1:0] cfg_secure,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  awprot_ns,
    input  logic                  wvalid,
    output logic                  wready,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [STRB_W-1:0]     wstrb,
    output logic                  bvalid,
    input  logic                  bready,
    output logic [1:0]            bresp,
    input  logic                  arvalid,
    output logic                  arready,
    input  logic [ADDR_W-1:0]     araddr,
    input  logic                  arprot_ns,
    output logic                  rvalid,
    input  logic                  rready,
    output logic [DATA_W-1:0]     rdata,
    output logic [1:0]            rresp,
    output logic [NUM_PERIPH-1:0] psel,
    output logic                  penable,
    output logic                  pwrite,
    output logic [ADDR_W-1:0]     paddr,
    output logic [DATA_W-1:0]     pwdata,
    output logic [STRB_W-1:0]     pstrb,
    input  logic [DATA_W-1:0]     prdata,
    input  logic                  pready,
    input  logic                  pslverr
);

    logic              idle;
    logic              wr_pending;
    logic              take_wr;
    logic              take_rd;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_ns;
    logic [IDX_W-1:0]  dec_idx;
    dec_res_e          dec_res;
    logic [1:0]        resp;

    // Writes win: a read is taken only when no complete write is offered.
    assign wr_pending = awvalid && wvalid;
    assign take_wr    = idle && wr_pending;
    assign take_rd    = idle && arvalid && !wr_pending;
    assign awready    = take_wr;
    assign wready     = take_wr;
    assign arready    = take_rd;
    assign sel_addr   = wr_pending ? awaddr : araddr;
    assign sel_ns     = wr_pending ? awprot_ns : arprot_ns;

    secbr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_PERIPH (NUM_PERIPH),
        .WIN_W      (WIN_W),
        .BASE_ADDR  (BASE_ADDR)
    ) u_decode (
        .addr_hi    (sel_addr[ADDR_W-1:WIN_W]),
        .nonsec     (sel_ns),
        .cfg_secure (cfg_secure),
        .idx        (dec_idx),
        .result     (dec_res)
    );

    secbr_apb_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_wr   (take_wr),
        .start_rd   (take_rd),
        .req_addr   (sel_addr),
        .req_wdata  (wdata),
        .req_strb   (wstrb),
        .dec_res    (dec_res),
        .dec_idx    (dec_idx),
        .idle       (idle),
        .bvalid     (bvalid),
        .bready     (bready),
        .rvalid     (rvalid),
        .rready     (rready),
        .resp       (resp),
        .rdata      (rdata),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .pstrb      (pstrb),
        .prdata     (prdata),
        .pready     (pready),
        .pslverr    (pslverr)
    );

    assign bresp = resp;
    assign rresp = resp;

    a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
        (bvalid || rvalid || (|psel)) |-> !(awready || wready || arready));

    a_r10_write_first: assert property (@(posedge clk) disable iff (rst)
        (awready && arvalid) |-> !arready);

endmodule

// File: tb/secure_apb_bridge_tb.sv
module secure_apb_bridge_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NP = 8;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] cfg_secure = 8'b0000_0101;
    logic          awvalid = 0, awready, awprot_ns = 0;
    logic [AW-1:0] awaddr = '0;
    logic          wvalid = 0, wready;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    wstrb = '0;
    logic          bvalid, bready = 1;
    logic [1:0]    bresp;
    logic          arvalid = 0, arready, arprot_ns = 0;
    logic [AW-1:0] araddr = '0;
    logic          rvalid, rready = 1;
    logic [DW-1:0] rdata;
    logic [1:0]    rresp;
    logic [NP-1:0] psel;
    logic          penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic [3:0]    pstrb;
    logic [DW-1:0] prdata;
    logic          pready = 0, pslverr = 0;

    int checks = 0;
    int errors = 0;

    // APB peripheral model state
    int            waits_g = 0;
    bit            err_g = 0;
    int            acc_cnt = 0;
    logic [NP-1:0] seen_psel;
    int            n_setup, n_access;
    bit            seen_any, first_write;
    logic [AW-1:0] seen_addr;
    logic [DW-1:0] seen_wdata;

    always #2 clk = ~clk;

    assign prdata = 32'h5A00_0000 ^ paddr;

    secure_apb_bridge u_dut (
        .clk(clk), .rst(rst), .cfg_secure(cfg_secure),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awprot_ns(awprot_ns),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arprot_ns(arprot_ns),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    always @(negedge clk) begin
        if (|psel) begin
            seen_psel  = seen_psel | psel;
            seen_addr  = paddr;
            seen_wdata = pwdata;
            if (!seen_any) begin
                seen_any    = 1;
                first_write = pwrite;
            end
        end
        if ((|psel) && !penable) n_setup++;
        if ((|psel) && penable) begin
            n_access++;
            pready  = (acc_cnt == waits_g);
            pslverr = pready && err_g;
            acc_cnt++;
        end else begin
            pready  = 0;
            pslverr = 0;
            acc_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        seen_psel = '0; n_setup = 0; n_access = 0; seen_any = 0; first_write = 0;
    endtask

    // One transfer; response handshake delayed by hold cycles (R11)
    task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] data,
                        input bit ns, input int waits, input bit err, input int hold,
                        output logic [1:0] resp, output logic [31:0] rd);
        bit done = 0;
        clear_mon();
        waits_g = waits; err_g = err;
        @(negedge clk);
        if (hold > 0) begin bready = 0; rready = 0; end
        if (wr) begin
            awvalid = 1; wvalid = 1; awaddr = addr; wdata = data; wstrb = 4'hF; awprot_ns = ns;
        end else begin
            arvalid = 1; araddr = addr; arprot_ns = ns;
        end
        @(negedge clk);
        awvalid = 0; wvalid = 0; arvalid = 0;
        for (int i = 0; i < 60 && !done; i++) begin
            chk(!(awready || arready), "R9", "ready low while busy", {awready, arready}, 0);
            if (wr ? bvalid : rvalid) done = 1;
            else @(negedge clk);
        end
        chk(done, "R11", "response arrived", done, 1);
        resp = wr ? bresp : rresp;
        rd   = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk((wr ? bvalid : rvalid) && ((wr ? bresp : rresp) == resp), "R11",
                "response held", wr ? bvalid : rvalid, 1);
        end
        bready = 1; rready = 1;
        @(negedge clk);
    endtask

    function automatic logic [31:0] win(input int k, input logic [11:0] off);
        return BASE + 32'(k) * 32'h1000 + 32'(off);
    endfunction

    task automatic t_reset();
        chk(psel == 0 && !penable, "R1", "apb idle after reset", {psel, penable}, 0);
        chk(!bvalid && !rvalid, "R1", "no response after reset", {bvalid, rvalid}, 0);
    endtask

    task automatic t_secure_to_secure();
        logic [1:0] r; logic [31:0] d;
        xfer(1, win(2, 12'h010), 32'hCAFE_0002, 0, 2, 0, 0, r, d);
        chk(r == 2'b00, "R4", "secure write to secure periph okay", r, 0);
        chk(seen_psel == 8'b0000_0100, "R2", "select line", seen_psel, 8'b0000_0100);
        chk(seen_addr == win(2, 12'h010), "R2", "paddr", seen_addr, win(2, 12'h010));
        chk(seen_wdata == 32'hCAFE_0002, "R2", "pwdata", seen_wdata, 32'hCAFE_0002);
        chk(n_setup == 1, "R3", "one setup cycle", n_setup, 1);
        chk(n_access == 3, "R3", "access cycles with 2 waits", n_access, 3);
        xfer(0, win(0, 12'h0F0), 0, 0, 0, 0, 0, r, d);
        chk(r == 2'b00 && seen_psel == 8'b0000_0001, "R4", "secure read of secure periph",
            {r, seen_psel}, 32'h001);
        chk(d == (32'h5A00_0000 ^ win(0, 12'h0F0)), "R8", "read data", d, 32'h5A00_0000 ^ win(0, 12'h0F0));
    endtask

    task automatic t_nonsec_allowed();
        logic [1:0] r; logic [31:0] d;
        xfer(1, win(3, 12'h004), 32'h1234_5678, 1, 0, 0, 0, r, d);
        chk(r == 2'b00 && seen_psel == 8'b0000_1000, "R5", "nonsec write to open periph",
            {r, seen_psel}, 32'h008);
        chk(n_access == 1, "R3", "zero-wait access", n_access, 1);
        xfer(0, win(5, 12'hFFC), 0, 1, 1, 0, 0, r, d);
        chk(r == 2'b00 && seen_psel == 8'b0010_0000, "R5", "nonsec read open periph",
            {r, seen_psel}, 32'h020);
        chk(d == (32'h5A00_0000 ^ win(5, 12'hFFC)), "R8", "read data", d, 32'h5A00_0000 ^ win(5, 12'hFFC));
        xfer(1, win(7, 12'h000), 32'h7, 1, 0, 0, 0, r, d);
        chk(seen_psel == 8'b1000_0000, "R2", "top window select", seen_psel, 8'b1000_0000);
    endtask

    task automatic t_blocked();
        logic [1:0] r; logic [31:0] d;
        xfer(1, win(0, 12'h020), 32'hDEAD_BEEF, 1, 0, 0, 0, r, d);
        chk(r == 2'b10, "R6", "nonsec write to secure gets SLVERR", r, 2'b10);
        chk(seen_psel == 0, "R6", "no select on refused write", seen_psel, 0);
        xfer(0, win(2, 12'h040), 0, 1, 0, 0, 0, r, d);
        chk(r == 2'b10 && seen_psel == 0, "R6", "refused read", {r, seen_psel}, 32'h200);
        chk(d == 0, "R6", "refused read data zero", d, 0);
    endtask

    task automatic t_unmapped();
        logic [1:0] r; logic [31:0] d;
        xfer(0, BASE + 32'h8000, 0, 0, 0, 0, 0, r, d);
        chk(r == 2'b11 && seen_psel == 0, "R7", "read past last window", {r, seen_psel}, 32'h300);
        chk(d == 0, "R7", "miss read data zero", d, 0);
        xfer(1, 32'h5000_0000, 32'h1, 1, 0, 0, 0, r, d);
        chk(r == 2'b11 && seen_psel == 0, "R7", "write outside region", {r, seen_psel}, 32'h300);
        xfer(1, BASE - 32'h4, 32'h1, 0, 0, 0, 0, r, d);
        chk(r == 2'b11 && seen_psel == 0, "R7", "write just below base", {r, seen_psel}, 32'h300);
    endtask

    task automatic t_slverr();
        logic [1:0] r; logic [31:0] d;
        xfer(1, win(6, 12'h100), 32'h6, 1, 1, 1, 0, r, d);
        chk(r == 2'b10 && seen_psel == 8'b0100_0000, "R8", "pslverr maps to SLVERR on write",
            {r, seen_psel}, 32'h240);
        xfer(0, win(4, 12'h100), 0, 0, 0, 1, 0, r, d);
        chk(r == 2'b10, "R8", "pslverr maps to SLVERR on read", r, 2'b10);
    endtask

    task automatic t_priority();
        bit done = 0;
        clear_mon();
        waits_g = 1; err_g = 0;
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = win(3, 12'h008); wdata = 32'hAAAA_5555; awprot_ns = 1;
        arvalid = 1; araddr = win(4, 12'h00C); arprot_ns = 1;
        #1;
        chk(awready && wready && !arready, "R10", "write wins tie", {awready, wready, arready}, 3'b110);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        for (int i = 0; i < 60 && !done; i++) begin
            chk(!arready, "R9", "read held off while write runs", arready, 0);
            if (bvalid) done = 1;
            else @(negedge clk);
        end
        chk(done && bresp == 2'b00, "R10", "write completes first", {done, bresp}, 3'b100);
        chk(first_write, "R10", "first apb cycle is a write", first_write, 1);
        @(negedge clk);
        chk(arready, "R10", "read taken after write response", arready, 1);
        @(negedge clk);
        arvalid = 0;
        clear_mon();
        done = 0;
        for (int i = 0; i < 60 && !done; i++) begin
            if (rvalid) done = 1;
            else @(negedge clk);
        end
        chk(done && rresp == 2'b00 && seen_psel == 8'b0001_0000, "R10", "deferred read served",
            {done, rresp, seen_psel}, 32'h410);
        chk(rdata == (32'h5A00_0000 ^ win(4, 12'h00C)), "R8", "deferred read data",
            rdata, 32'h5A00_0000 ^ win(4, 12'h00C));
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [1:0] r; logic [31:0] d;
        xfer(1, win(0, 12'h0), 32'h1, 1, 0, 0, 3, r, d);
        chk(r == 2'b10, "R11", "held write response code", r, 2'b10);
        xfer(0, win(1, 12'h0), 0, 1, 0, 0, 2, r, d);
        chk(r == 2'b00 && d == (32'h5A00_0000 ^ win(1, 12'h0)), "R11", "held read data", d,
            32'h5A00_0000 ^ win(1, 12'h0));
    endtask

    initial begin
        clear_mon();
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 0;
        t_secure_to_secure();
        t_nonsec_allowed();
        t_blocked();
        t_unmapped();
        t_slverr();
        t_priority();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule